// File: doc/BRIEF.md
# Time-Multiplexed Multi-Context Accumulator Engine

This block makes one shared copy of a small accumulator datapath do the work of `N_CTX` identical processing elements. Each element has its own `DATA_W`-bit state word. The state words sit in an `N_CTX`-deep store that rotates by one element on every fast iteration clock. On each iteration cycle the word of one element comes out of the store. The shared next-state logic combines it with that slot's instruction and operand, and the result goes back into the store. One pass over all elements, in index order 0 up to `N_CTX-1`, makes one virtual cycle of the emulated system. The iteration clock therefore runs `N_CTX` times faster than the virtual clock. For example, two elements at a 15.2 MHz iteration rate give a 7.6 MHz virtual rate.

The store is built in one of two forms, chosen by a parameter. One form is a chain of shift registers, one stage per element. The other is an addressable memory with its own rotating pointer. Both forms give the same behaviour on every cycle.

A surrounding system watches `slot_idx` to see which element is being served, and drives that element's instruction in the same cycle. It collects the evaluated element's new state one cycle later, tagged with that element's index. `vc_done` marks the last slot of each virtual cycle. A synchronous reset loads every element's state with a parameterised value.

Top module: `ctx_mux_engine`

## Requirements
- R1: After reset `slot_idx` is 0. It then increases by one on every clock and wraps from `N_CTX-1` to 0.
- R2: `vc_done` is 1 exactly in the cycles where `slot_idx` equals `N_CTX-1`, and 0 in all other cycles, including during reset.
- R3: In the slot of element k, the element's new state is computed from `in_op` as follows, modulo 2^`DATA_W`. Code 0 keeps the state. Code 1 adds `in_operand`. Code 2 subtracts `in_operand`. Code 3 loads `in_operand`.
- R4: The instruction and operand sampled in element k's slot change only element k's state. Every other element keeps its value.
- R5: A synchronous reset sets every element's state to `RESET_VAL` and drives `res_valid` to 0. The first evaluation after reset works on `RESET_VAL`.
- R6: The cycle after each non-reset slot, `res_valid` is 1. In that cycle `res_idx` holds the index of the element that was evaluated, and `res_state` holds that element's new state.
- R7: The shift-chain store (`STORE_KIND`=0) and the addressable-memory store (`STORE_KIND`=1) produce identical outputs on every cycle.
- R8: The state written for element k is the state the shared logic works on in element k's next slot, `N_CTX` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Iteration clock |
| rst | input | 1 | Synchronous active-high reset; loads every element's state |
| in_op | input | 2 | Instruction for the element in the current slot (0 hold, 1 add, 2 subtract, 3 load) |
| in_operand | input | DATA_W | Operand for the element in the current slot |
| slot_idx | output | IDX_W | Index of the element served in this cycle |
| vc_done | output | 1 | High in the last slot of a virtual cycle |
| res_valid | output | 1 | Result registers hold an evaluation |
| res_idx | output | IDX_W | Index of the element evaluated in the previous cycle |
| res_state | output | DATA_W | New state of that element |

## Verification
On every cycle, the assertions check the following: the slot counter steps and wraps correctly, `vc_done` lines up with the last slot, the result index follows the slot of the cycle before, and the store presents `RESET_VAL` right after reset. Only the bench's scenarios can show the per-element arithmetic, the isolation of one element from another's inputs, and the return of a written state to its element a full virtual cycle later. Those scenarios run reference models, one per element. The bench also drives both store forms side by side and compares them, and it checks that a reset in the middle of a run reloads every element.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
package ctx_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_LOAD = 2'd3
    } ctx_op_e;

    localparam int STORE_SHIFT = 0;
    localparam int STORE_MEM   = 1;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ctx_slot_counter.sv
`timescale 1ns/1ps
module ctx_slot_counter #(
    parameter int N_CTX = 4,
    localparam int IDX_W = ctx_pkg::idx_width(N_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CTX - 1);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (idx == LAST_IDX)
            idx <= '0;
        else
            idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);

    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (idx == LAST_IDX) |=> (idx == '0));

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1));

    a_r1_reset: assert property (@(posedge clk)
        $past(rst) |-> (idx == '0));

endmodule

// File: rtl/ctx_state_store.sv
`timescale 1ns/1ps
module ctx_state_store #(
    parameter int              N_CTX      = 4,
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = '0,
    parameter int              STORE_KIND = ctx_pkg::STORE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_state,
    output logic [DATA_W-1:0] rd_state
);
    localparam int IDX_W = ctx_pkg::idx_width(N_CTX);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CTX - 1);

    generate
        if (STORE_KIND == ctx_pkg::STORE_SHIFT) begin : g_shift
            logic [DATA_W-1:0] stage [N_CTX];

            for (genvar s = 0; s < N_CTX; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        stage[s] <= RESET_VAL;
                    else if (s == N_CTX - 1)
                        stage[s] <= wr_state;
                    else
                        stage[s] <= stage[(s + 1) % N_CTX];
                end
            end

            assign rd_state = stage[0];
        end else begin : g_mem
            logic [DATA_W-1:0] mem [N_CTX];
            logic [IDX_W-1:0]  ptr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ptr <= '0;
                    for (int e = 0; e < N_CTX; e++)
                        mem[e] <= RESET_VAL;
                end else begin
                    mem[ptr] <= wr_state;
                    ptr      <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
                end
            end

            assign rd_state = mem[ptr];
        end
    endgenerate

    a_r5_reset_head: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_state == RESET_VAL));

endmodule

// File: rtl/ctx_next_state.sv
`timescale 1ns/1ps
module ctx_next_state #(
    parameter int DATA_W = 8
) (
    input  ctx_pkg::ctx_op_e  op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] cur_state,
    output logic [DATA_W-1:0] nxt_state
);
    import ctx_pkg::*;

    always_comb begin
        unique case (op)
            OP_HOLD: nxt_state = cur_state;
            OP_ADD:  nxt_state = cur_state + operand;
            OP_SUB:  nxt_state = cur_state - operand;
            OP_LOAD: nxt_state = operand;
            default: nxt_state = cur_state;
        endcase
    end

    always_comb begin
        if (op == OP_LOAD)
            a_r3_load: assert (nxt_state == operand);
    end

endmodule

// File: rtl/ctx_mux_engine.sv
`timescale 1ns/1ps
module ctx_mux_engine #(
    parameter int                N_CTX      = 4,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] RESET_VAL  = '0,
    parameter int                STORE_KIND = ctx_pkg::STORE_SHIFT,
    localparam int               IDX_W      = ctx_pkg::idx_width(N_CTX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_operand,
    output logic [IDX_W-1:0]  slot_idx,
    output logic              vc_done,
    output logic              res_valid,
    output logic [IDX_W-1:0]  res_idx,
    output logic [DATA_W-1:0] res_state
);
    import ctx_pkg::*;

    logic [DATA_W-1:0] head_state;
    logic [DATA_W-1:0] next_state;
    logic              slot_last;
    ctx_op_e           op_dec;

    assign op_dec = ctx_op_e'(in_op);

    ctx_slot_counter #(.N_CTX(N_CTX)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .idx  (slot_idx),
        .last (slot_last)
    );

    ctx_state_store #(
        .N_CTX      (N_CTX),
        .DATA_W     (DATA_W),
        .RESET_VAL  (RESET_VAL),
        .STORE_KIND (STORE_KIND)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_state (next_state),
        .rd_state (head_state)
    );

    ctx_next_state #(.DATA_W(DATA_W)) u_logic (
        .op        (op_dec),
        .operand   (in_operand),
        .cur_state (head_state),
        .nxt_state (next_state)
    );

    assign vc_done = slot_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_idx   <= '0;
            res_state <= RESET_VAL;
        end else begin
            res_valid <= 1'b1;
            res_idx   <= slot_idx;
            res_state <= next_state;
        end
    end

    a_r6_tag: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (res_valid && res_idx == $past(slot_idx)));

    a_r2_done_last: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_idx == IDX_W'(N_CTX - 1)) |-> $past(vc_done));

    a_r5_res_clear: assert property (@(posedge clk)
        $past(rst) |-> !res_valid);

endmodule

// File: tb/ctx_mux_engine_tb_top.sv
`timescale 1ns/1ps
module ctx_mux_engine_tb_top;
    localparam int N     = 4;
    localparam int W     = 8;
    localparam int IW    = 2;
    localparam logic [W-1:0] RV = 8'h3C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    in_op = 2'd0;
    logic [W-1:0]  in_operand = '0;

    logic [IW-1:0] slot_s, slot_m, ridx_s, ridx_m;
    logic          vcd_s, vcd_m, rv_s, rv_m;
    logic [W-1:0]  rst_s, rst_m;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [W-1:0] model [N];
    logic [W-1:0] exp_state;
    int           prev_k;
    bit           have_prev;

    always #2.5 clk = ~clk;

    ctx_mux_engine #(.N_CTX(N), .DATA_W(W), .RESET_VAL(RV), .STORE_KIND(0)) dut_i (
        .clk(clk), .rst(rst), .in_op(in_op), .in_operand(in_operand),
        .slot_idx(slot_s), .vc_done(vcd_s), .res_valid(rv_s),
        .res_idx(ridx_s), .res_state(rst_s)
    );

    ctx_mux_engine #(.N_CTX(N), .DATA_W(W), .RESET_VAL(RV), .STORE_KIND(1)) dut_mem_i (
        .clk(clk), .rst(rst), .in_op(in_op), .in_operand(in_operand),
        .slot_idx(slot_m), .vc_done(vcd_m), .res_valid(rv_m),
        .res_idx(ridx_m), .res_state(rst_m)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_step(input logic [1:0] op,
                                              input logic [W-1:0] s,
                                              input logic [W-1:0] a);
        case (op)
            2'd0: return s;
            2'd1: return W'(s + a);
            2'd2: return W'(s - a);
            default: return a;
        endcase
    endfunction

    // One iteration slot: called at a negedge, checks then drives.
    task automatic slot(input int k, input logic [1:0] op, input logic [W-1:0] a);
        chk("R1 slot_idx", 32'(slot_s), 32'(k));
        chk("R2 vc_done", 32'(vcd_s), 32'(k == N - 1));
        chk("R7 slot/done match", 32'({slot_m, vcd_m}), 32'({slot_s, vcd_s}));
        if (have_prev) begin
            chk("R6 res_valid", 32'(rv_s), 32'd1);
            chk("R6 res_idx", 32'(ridx_s), 32'(prev_k));
            chk("R3 R4 R8 res_state", 32'(rst_s), 32'(exp_state));
            chk("R7 result match", 32'({rv_m, ridx_m, rst_m}), 32'({rv_s, ridx_s, rst_s}));
        end
        in_op      = op;
        in_operand = a;
        exp_state  = ref_step(op, model[k], a);
        model[k]   = exp_state;
        prev_k     = k;
        have_prev  = 1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_op = 2'd0;
        in_operand = '0;
        repeat (3) @(negedge clk);
        chk("R5 res_valid in reset", 32'(rv_s), 32'd0);
        chk("R1 slot_idx in reset", 32'(slot_s), 32'd0);
        chk("R2 vc_done in reset", 32'(vcd_s), 32'd0);
        chk("R7 reset match", 32'({rv_m, slot_m, vcd_m}), 32'({rv_s, slot_s, vcd_s}));
        for (int e = 0; e < N; e++) model[e] = RV;
        have_prev = 0;
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R5: first virtual cycle holds, every element must show RESET_VAL
        for (int k = 0; k < N; k++) slot(k, 2'd0, 8'hFF);

        // R3: sweep all opcodes against many operands and rotations per element
        for (int c = 0; c < 64 * N; c++)
            slot(c % N, 2'((c / N + c % N) % 4), W'(c * 29 + 7));

        // R4: only element 2 is loaded, the others hold across virtual cycles
        for (int v = 0; v < 3; v++)
            for (int k = 0; k < N; k++)
                slot(k, (k == 2 && v == 0) ? 2'd3 : 2'd0, 8'hA5);

        // R8: add with wrap, state returns one virtual cycle later
        for (int v = 0; v < 4; v++)
            for (int k = 0; k < N; k++)
                slot(k, 2'd1, 8'hF0 + W'(k));

        // R5: reset mid-run reloads every element
        do_reset();
        for (int v = 0; v < 2; v++)
            for (int k = 0; k < N; k++) slot(k, 2'd0, 8'h11);
        // final pending result
        slot(0, 2'd0, 8'h00);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule